// File: doc/BRIEF.md
# Make-Unique Upgrade Sequencer

This block is the ownership-upgrade path of a write-back data cache's miss handler. A store-side controller that wants to write a line it does not hold uniquely hands the line address to the sequencer. The sequencer does not trust the state that was current when the store was first seen. Before it touches the bus it looks the line state up again, because a snoop may have removed the line in the meantime. A line that is still shared is upgraded with a CleanUnique request. A line that has gone invalid is fetched whole with a ReadUnique request.

While a CleanUnique is outstanding, the sequencer watches the snoop notifications for its own line. An invalidating snoop (CleanInvalid or ReadUnique) means the local copy is gone. The sequencer then follows the CleanUnique with a ReadUnique and writes the returned data into the line itself. A ReadShared snoop means another cache kept a copy, so the sequencer looks the state up again and sends CleanUnique once more.

When the upgrade is done, the sequencer writes the line state to unique-dirty and pulses done to the requester for one cycle. The pulse carries a flag that says whether the line data has already been written, so the requester knows whether it still has to perform its own cache write.

Top module: `upgrade_sequencer`

## Requirements
- R1: Out of reset `reqReady` is 1, and `busReqValid`, `doneValid` and `lineWrEn` are 0.
- R2: A request is taken only while `reqReady` is 1. `reqReady` stays 0 from the cycle after acceptance until the cycle after the `doneValid` pulse, and it is 1 only when no bus request or done pulse is being driven.
- R3: After acceptance the sequencer samples `lookupState` (0 invalid, 1 shared-clean, 2 shared-dirty, 3 unique-clean, 4 unique-dirty). For state 1 or 2 it issues CleanUnique (`busReqUnique`=0). For state 0 it issues ReadUnique (`busReqUnique`=1). In both cases `lineAddr` equals the accepted address.
- R4: If the looked-up state is 3 or 4, no bus request is made, and completion follows with `doneWrote`=0.
- R5: A snoop of kind CleanInvalid (3) or ReadUnique (2) that hits the line is an invalidating collision. It counts in any cycle from the CleanUnique request through its response cycle. After that CleanUnique completes, a ReadUnique is issued, its response data is written to the line, and `doneWrote`=1. An invalidating collision takes priority over a ReadShared collision in the same window.
- R6: A ReadShared (1) snoop hitting the line in the same window, with no invalidating collision, causes the state to be looked up again and CleanUnique to be sent again. Completion follows with `doneWrote`=0.
- R7: A snoop hits the line when `snpAddr[ADDR_W-1:OFF_W]` equals the held address in the same bits. Offset bits are ignored. Snoops to other lines and ReadOnce (0) snoops have no effect.
- R8: Completion is a one-cycle `doneValid` pulse. In that same cycle `lineWrEn`=1, `lineWrState`=4, `lineAddr` is the held address, and `lineWrDataEn` equals `doneWrote`. When `doneWrote`=1, `lineWrData` is the ReadUnique response data.
- R9: While `busReqValid` is 1 and `busReqReady` is 0, the request stays valid with unchanged `busReqUnique` and `lineAddr`. Exactly one request counts when the handshake completes.
- R10: Snoops that arrive while a ReadUnique is outstanding have no effect. Completion still follows with `doneWrote`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Make-unique request from a store controller |
| reqAddr | input | ADDR_W | Byte address of the line to upgrade |
| reqReady | output | 1 | Sequencer is idle and takes a request |
| lookupState | input | 3 | Current state of the held line (0 I, 1 SC, 2 SD, 3 UC, 4 UD) |
| busReqValid | output | 1 | Coherent bus request valid |
| busReqUnique | output | 1 | 1 ReadUnique, 0 CleanUnique |
| busReqReady | input | 1 | Bus accepts the request |
| busRespValid | input | 1 | Bus response for the outstanding request |
| busRespData | input | LINE_W | Line data carried by a ReadUnique response |
| snpValid | input | 1 | Snoop notification valid |
| snpKind | input | 2 | 0 ReadOnce, 1 ReadShared, 2 ReadUnique, 3 CleanInvalid |
| snpAddr | input | ADDR_W | Snooped address |
| lineAddr | output | ADDR_W | Held address for lookup, bus request and line write |
| lineWrEn | output | 1 | Line update strobe |
| lineWrState | output | 3 | New line state (always 4, unique-dirty) |
| lineWrDataEn | output | 1 | Line data is written as well |
| lineWrData | output | LINE_W | Data to write into the line |
| doneValid | output | 1 | One-cycle completion pulse to the requester |
| doneWrote | output | 1 | Sequencer has already written the line data |

## Verification
The hardest situations to reach from the ports are collisions that land on a precise cycle of an outstanding CleanUnique. These are a snoop in the very cycle the response returns, and a ReadShared followed by a CleanInvalid within the same window. The bench plays the bus itself and counts request handshakes. Each scenario arms snoop slots that fire a given number of cycles after a chosen handshake, so a snoop can be placed anywhere between the request and its response. The same scheduling places invalidating snoops inside a ReadUnique window to show they are ignored, and holds `busReqReady` low to show the request is kept.

// File: rtl/upgrade_pkg.sv
`timescale 1ns/1ps
package upgrade_pkg;

  typedef enum logic [2:0] {
    LS_INV = 3'd0,
    LS_SC  = 3'd1,
    LS_SD  = 3'd2,
    LS_UC  = 3'd3,
    LS_UD  = 3'd4
  } lineState_e;

  typedef enum logic [1:0] {
    SN_READ_ONCE   = 2'd0,
    SN_READ_SHARED = 2'd1,
    SN_READ_UNIQUE = 2'd2,
    SN_CLEAN_INV   = 2'd3
  } snoopKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic clearColl;
    logic watchSnoop;
    logic captureData;
  } seqStrobe_t;

endpackage

// File: rtl/upgrade_dpath.sv
`timescale 1ns/1ps
module upgrade_dpath
  import upgrade_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              snpValid,
  input  logic [1:0]        snpKind,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [LINE_W-1:0] busRespData,
  output logic [ADDR_W-1:0] heldAddr,
  output logic [LINE_W-1:0] heldData,
  output logic              collInv,
  output logic              collShared,
  output logic              dataWritten
);

  localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W)'((64'd1 << OFF_W) - 64'd1));

  logic invSeen;
  logic sharedSeen;
  logic lineHit;
  logic hitInv;
  logic hitShared;
  snoopKind_e kindNow;

  assign kindNow   = snoopKind_e'(snpKind);
  assign lineHit   = snpValid && strobe.watchSnoop &&
                     ((snpAddr & LINE_MASK) == (heldAddr & LINE_MASK));
  assign hitInv    = lineHit && (kindNow == SN_CLEAN_INV || kindNow == SN_READ_UNIQUE);
  assign hitShared = lineHit && (kindNow == SN_READ_SHARED);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldAddr    <= '0;
      heldData    <= '0;
      invSeen     <= 1'b0;
      sharedSeen  <= 1'b0;
      dataWritten <= 1'b0;
    end else begin
      if (strobe.loadAddr) begin
        heldAddr    <= reqAddr;
        dataWritten <= 1'b0;
      end
      if (strobe.clearColl) begin
        invSeen    <= 1'b0;
        sharedSeen <= 1'b0;
      end else begin
        invSeen    <= invSeen | hitInv;
        sharedSeen <= sharedSeen | hitShared;
      end
      if (strobe.captureData) begin
        heldData    <= busRespData;
        dataWritten <= 1'b1;
      end
    end
  end

  // include the current cycle so a snoop beside the response still counts
  assign collInv    = invSeen | hitInv;
  assign collShared = sharedSeen | hitShared;

endmodule

// File: rtl/upgrade_ctrl.sv
`timescale 1ns/1ps
module upgrade_ctrl
  import upgrade_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] lookupState,
  input  logic       busReqReady,
  input  logic       busRespValid,
  input  logic       collInv,
  input  logic       collShared,
  output seqStrobe_t strobe,
  output logic       reqReady,
  output logic       busReqValid,
  output logic       busReqUnique,
  output logic       finish
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_CLEAN_REQ, ST_CLEAN_WAIT, ST_MISS_REQ, ST_MISS_WAIT, ST_FINISH
  } seqState_e;

  seqState_e stateQ;
  seqState_e stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (reqValid) stateD = ST_CHECK;
      ST_CHECK: begin
        unique case (lineState_e'(lookupState))
          LS_INV:        stateD = ST_MISS_REQ;
          LS_SC, LS_SD:  stateD = ST_CLEAN_REQ;
          default:       stateD = ST_FINISH;
        endcase
      end
      ST_CLEAN_REQ:  if (busReqReady) stateD = ST_CLEAN_WAIT;
      ST_CLEAN_WAIT: begin
        if (busRespValid) begin
          if (collInv)         stateD = ST_MISS_REQ;
          else if (collShared) stateD = ST_CHECK;
          else                 stateD = ST_FINISH;
        end
      end
      ST_MISS_REQ:  if (busReqReady) stateD = ST_MISS_WAIT;
      ST_MISS_WAIT: if (busRespValid) stateD = ST_FINISH;
      ST_FINISH:    stateD = ST_IDLE;
      default:      stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.loadAddr    = (stateQ == ST_IDLE) && reqValid;
    strobe.clearColl   = (stateQ == ST_CHECK);
    strobe.watchSnoop  = (stateQ == ST_CLEAN_REQ) || (stateQ == ST_CLEAN_WAIT);
    strobe.captureData = (stateQ == ST_MISS_WAIT) && busRespValid;
  end

  assign reqReady     = (stateQ == ST_IDLE);
  assign busReqValid  = (stateQ == ST_CLEAN_REQ) || (stateQ == ST_MISS_REQ);
  assign busReqUnique = (stateQ == ST_MISS_REQ);
  assign finish       = (stateQ == ST_FINISH);

endmodule

// File: rtl/upgrade_sequencer.sv
`timescale 1ns/1ps
module upgrade_sequencer
  import upgrade_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  input  logic [2:0]        lookupState,
  output logic              busReqValid,
  output logic              busReqUnique,
  input  logic              busReqReady,
  input  logic              busRespValid,
  input  logic [LINE_W-1:0] busRespData,
  input  logic              snpValid,
  input  logic [1:0]        snpKind,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic [ADDR_W-1:0] lineAddr,
  output logic              lineWrEn,
  output logic [2:0]        lineWrState,
  output logic              lineWrDataEn,
  output logic [LINE_W-1:0] lineWrData,
  output logic              doneValid,
  output logic              doneWrote
);

  seqStrobe_t strobe;
  logic       collInv;
  logic       collShared;
  logic       dataWritten;
  logic       finish;

  upgrade_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .lookupState (lookupState),
    .busReqReady (busReqReady),
    .busRespValid(busRespValid),
    .collInv     (collInv),
    .collShared  (collShared),
    .strobe      (strobe),
    .reqReady    (reqReady),
    .busReqValid (busReqValid),
    .busReqUnique(busReqUnique),
    .finish      (finish)
  );

  upgrade_dpath #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W),
    .LINE_W(LINE_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .snpValid   (snpValid),
    .snpKind    (snpKind),
    .snpAddr    (snpAddr),
    .busRespData(busRespData),
    .heldAddr   (lineAddr),
    .heldData   (lineWrData),
    .collInv    (collInv),
    .collShared (collShared),
    .dataWritten(dataWritten)
  );

  assign doneValid    = finish;
  assign doneWrote    = dataWritten;
  assign lineWrEn     = finish;
  assign lineWrState  = LS_UD;
  assign lineWrDataEn = dataWritten;

endmodule

// File: rtl/upgrade_sequencer_chk.sv
`timescale 1ns/1ps
module upgrade_sequencer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              busReqValid,
  input logic              busReqUnique,
  input logic              busReqReady,
  input logic [ADDR_W-1:0] lineAddr,
  input logic              lineWrEn,
  input logic [2:0]        lineWrState,
  input logic              lineWrDataEn,
  input logic              doneValid,
  input logic              doneWrote
);

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busReqValid && !doneValid);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid && !busReqReady |=> busReqValid && $stable(busReqUnique) && $stable(lineAddr));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  assert_done_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> lineWrEn && (lineWrState == 3'd4) && (lineWrDataEn == doneWrote));

endmodule

bind upgrade_sequencer upgrade_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/upgrade_sequencer_bench.sv
`timescale 1ns/1ps
module upgrade_sequencer_bench;

  localparam int ADDR_W = 32;
  localparam int OFF_W  = 6;
  localparam int LINE_W = 128;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqReady;
  logic [2:0]        lookupState = 3'd0;
  logic              busReqValid;
  logic              busReqUnique;
  logic              busReqReady = 1'b1;
  logic              busRespValid = 1'b0;
  logic [LINE_W-1:0] busRespData = '0;
  logic              snpValid = 1'b0;
  logic [1:0]        snpKind = 2'd0;
  logic [ADDR_W-1:0] snpAddr = '0;
  logic [ADDR_W-1:0] lineAddr;
  logic              lineWrEn;
  logic [2:0]        lineWrState;
  logic              lineWrDataEn;
  logic [LINE_W-1:0] lineWrData;
  logic              doneValid;
  logic              doneWrote;

  always #2.5 clk = ~clk;

  upgrade_sequencer #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LINE_W(LINE_W)) u_upgrade_sequencer (.*);

  int total = 0;
  int bad = 0;
  int wdFail = 0;
  int cycles = 0;

  // bus/monitor state, owned by the bus process
  bit          opLog [64];
  int          opCnt = 0;
  int          respIdx = 0;
  int          waitCnt = 0;
  bit          pending = 1'b0;
  int          stallRun = 0;
  int          stallCnt = 0;
  int          addrBad = 0;
  int          busyBad = 0;
  int          acceptCnt = 0;
  int          doneCnt = 0;
  bit          gotWrote, gotWrEn, gotDataEn;
  logic [2:0]  gotState;
  logic [ADDR_W-1:0] gotAddr;
  logic [LINE_W-1:0] gotData;

  // scenario configuration, owned by the initial block
  logic [ADDR_W-1:0] curAddr = '0;
  int          respLat = 3;
  int          stallTarget = 0;
  bit          aEn = 0, bEn = 0;
  int          aReq = 0, aAt = 0, bReq = 0, bAt = 0;
  int          aRel = 0, bRel = 0;
  logic [1:0]  aKind = 0, bKind = 0;
  logic [ADDR_W-1:0] aAddr = '0, bAddr = '0;

  function automatic logic [LINE_W-1:0] dataFor(input int n);
    return {(LINE_W/32){32'hC0DE0000 + 32'(n)}};
  endfunction

  always begin
    @(negedge clk);
    if (reqReady && acceptCnt != doneCnt) busyBad++;
    if (reqValid && reqReady) acceptCnt++;
    if (busReqValid && busReqReady) begin
      opLog[opCnt] = busReqUnique;
      if (lineAddr != curAddr) addrBad++;
      respIdx = opCnt;
      opCnt++;
      pending = 1'b1;
      waitCnt = 0;
      stallRun = 0;
    end else if (busReqValid) begin
      stallCnt++;
    end
    if (doneValid) begin
      doneCnt++;
      gotWrote  = doneWrote;
      gotWrEn   = lineWrEn;
      gotDataEn = lineWrDataEn;
      gotState  = lineWrState;
      gotAddr   = lineAddr;
      gotData   = lineWrData;
    end
    @(posedge clk);
    #1;
    snpValid = 1'b0;
    busRespValid = 1'b0;
    if (pending) begin
      waitCnt++;
      if (aEn && aReq == respIdx && aAt == waitCnt) begin
        snpValid = 1'b1; snpKind = aKind; snpAddr = aAddr;
      end
      if (bEn && bReq == respIdx && bAt == waitCnt) begin
        snpValid = 1'b1; snpKind = bKind; snpAddr = bAddr;
      end
      if (waitCnt == respLat) begin
        busRespValid = 1'b1;
        busRespData = dataFor(respIdx);
        pending = 1'b0;
      end
    end
    if (busReqValid && stallRun < stallTarget) begin
      busReqReady = 1'b0;
      stallRun++;
    end else begin
      busReqReady = 1'b1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      wdFail = 1;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic armA(input int rel, input int at, input logic [1:0] kind, input logic [ADDR_W-1:0] a);
    aEn = 1; aRel = rel; aAt = at; aKind = kind; aAddr = a;
  endtask

  task automatic armB(input int rel, input int at, input logic [1:0] kind, input logic [ADDR_W-1:0] a);
    bEn = 1; bRel = rel; bAt = at; bKind = kind; bAddr = a;
  endtask

  // one upgrade: request, wait for completion, then compare against expectations
  task automatic runCase(input string req, input logic [ADDR_W-1:0] addr, input logic [2:0] st,
                         input int nOps, input logic [2:0] expOps, input bit expWrote);
    int base, dBase, sBase, aBase, bBase;
    base  = opCnt;
    dBase = doneCnt;
    sBase = stallCnt;
    aBase = addrBad;
    bBase = busyBad;
    aReq = base + aRel;
    bReq = base + bRel;
    curAddr = addr;
    @(posedge clk); #1;
    lookupState = st;
    reqAddr = addr;
    reqValid = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (doneCnt != dBase) break;
    end
    repeat (3) @(negedge clk);
    check(req, "done pulses", 128'(doneCnt - dBase), 128'd1);
    check(req, "bus request count", 128'(opCnt - base), 128'(nOps));
    for (int i = 0; i < nOps; i++)
      check(req, "request kind", 128'(opLog[base + i]), 128'(expOps[i]));
    check(req, "doneWrote", 128'(gotWrote), 128'(expWrote));
    check("R8", "line write strobe", 128'(gotWrEn), 128'd1);
    check("R8", "line write state", 128'(gotState), 128'd4);
    check("R8", "line data enable", 128'(gotDataEn), 128'(expWrote));
    check("R8", "line address", 128'(gotAddr), 128'(addr));
    if (expWrote)
      check("R8", "line data", gotData, dataFor(base + nOps - 1));
    check("R3", "request address mismatches", 128'(addrBad - aBase), 128'd0);
    check("R2", "ready while busy", 128'(busyBad - bBase), 128'd0);
    if (stallTarget > 0)
      check("R9", "stalled request cycles", 128'(stallCnt - sBase), 128'(stallTarget));
    aEn = 0;
    bEn = 0;
    stallTarget = 0;
  endtask

  localparam logic [ADDR_W-1:0] A0 = 32'h0000_1240;
  localparam logic [ADDR_W-1:0] A_SAME_OFF = 32'h0000_127C;
  localparam logic [ADDR_W-1:0] A_OTHER = 32'h0000_1280;

  task automatic testReset;
    @(negedge clk);
    check("R1", "reqReady", 128'(reqReady), 128'd1);
    check("R1", "busReqValid", 128'(busReqValid), 128'd0);
    check("R1", "doneValid", 128'(doneValid), 128'd0);
    check("R1", "lineWrEn", 128'(lineWrEn), 128'd0);
  endtask

  task automatic testSharedClean;   runCase("R3", A0, 3'd1, 1, 3'b000, 1'b0); endtask
  task automatic testSharedDirty;   runCase("R3", A0, 3'd2, 1, 3'b000, 1'b0); endtask
  task automatic testInvalid;       runCase("R3", A0, 3'd0, 1, 3'b001, 1'b1); endtask
  task automatic testUniqueClean;   runCase("R4", A0, 3'd3, 0, 3'b000, 1'b0); endtask
  task automatic testUniqueDirty;   runCase("R4", A0, 3'd4, 0, 3'b000, 1'b0); endtask

  task automatic testCleanInvCollision;
    armA(0, 1, 2'd3, A0);
    runCase("R5", A0, 3'd1, 2, 3'b010, 1'b1);
  endtask

  task automatic testReadUniqueOnResp;
    armA(0, 3, 2'd2, A0);
    runCase("R5", A0, 3'd2, 2, 3'b010, 1'b1);
  endtask

  task automatic testReadSharedRetry;
    armA(0, 2, 2'd1, A0);
    runCase("R6", A0, 3'd1, 2, 3'b000, 1'b0);
  endtask

  task automatic testInvBeatsShared;
    armA(0, 1, 2'd1, A0);
    armB(0, 2, 2'd3, A0);
    runCase("R5", A0, 3'd1, 2, 3'b010, 1'b1);
  endtask

  task automatic testOtherLine;
    armA(0, 1, 2'd3, A_OTHER);
    runCase("R7", A0, 3'd1, 1, 3'b000, 1'b0);
  endtask

  task automatic testSameLineOffset;
    armA(0, 2, 2'd1, A_SAME_OFF);
    runCase("R7", A0, 3'd1, 2, 3'b000, 1'b0);
  endtask

  task automatic testReadOnce;
    armA(0, 1, 2'd0, A0);
    runCase("R7", A0, 3'd2, 1, 3'b000, 1'b0);
  endtask

  task automatic testSnoopDuringMiss;
    armA(0, 1, 2'd3, A0);
    armB(0, 2, 2'd1, A0);
    runCase("R10", A0, 3'd0, 1, 3'b001, 1'b1);
  endtask

  task automatic testStalledRequest;
    stallTarget = 2;
    runCase("R9", A_OTHER, 3'd1, 1, 3'b000, 1'b0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testSharedClean();
    testSharedDirty();
    testInvalid();
    testUniqueClean();
    testUniqueDirty();
    testCleanInvCollision();
    testReadUniqueOnResp();
    testReadSharedRetry();
    testInvBeatsShared();
    testOtherLine();
    testSameLineOffset();
    testReadOnce();
    testSnoopDuringMiss();
    testStalledRequest();
    $display("test done: total=%0d bad=%0d", total + wdFail, bad + wdFail);
    $finish;
  end

endmodule